// File: doc/BRIEF.md
# Clock Frequency Watchdog

This block protects a software-initiated clock frequency change. Before software moves the clock away from the strapped setting, it arms the watchdog. If software does not confirm the new setting by servicing the watchdog in time, the watchdog raises an alarm. In the case of a hard alarm, it also asks the clock generator to fall back to the frequency set by the hardware straps. At the same time it issues a one-cycle request that clears the software clock-mode control bit.

The timeout is a whole number of time-base units. An external prescaler delivers one `tick_i` pulse for each short unit (nominally 290 ms). The long unit is four short units (nominally 1160 ms). A 3-bit unit count sets the length of the timeout. There are two alarm modes:
- In hard-only mode, the first expiry raises the hard alarm.
- In dual mode, the first expiry raises a soft alarm. A second expiry, one full timeout later and still without service, raises the hard alarm.

A re-arm option re-enables the watchdog automatically when the chip leaves power-down.

Top module: `fwd_top`

## Requirements
- R1: After reset the control fields read disabled (`arm_o`=0), hard-only mode (`dual_o`=0), short time base (`long_o`=0), unit count 7 (`units_o`=3'b111) and auto re-arm off (`rearm_o`=0). All alarm outputs are 0.
- R2: While the watchdog is armed and not serviced, the timeout expires on the N-th counted tick. N is the unit count times the base length. A unit count of 0 counts as one unit. In hard-only mode, the expiry sets `hard_alarm_o`. Cycles with `tick_i`=0 are not counted.
- R3: With `long_o`=1, each unit is 4 ticks. With `long_o`=0, each unit is 1 tick.
- R4: With `dual_o`=1, the first expiry sets only `soft_alarm_o`. `hard_alarm_o` is set on the expiry one further full timeout later.
- R5: When the hard alarm fires, `hard_alarm_o` and `revert_o` rise together. `sw_mode_clr_o` pulses high for exactly that first cycle. Counting then stops, and the flags hold until a restart.
- R6: A `kick_i` pulse while armed, with no hard alarm, restarts the timeout from zero. A kick after a hard alarm changes nothing.
- R7: A control write (`ctl_wr_i`) loads all fields, restarts the count, and clears `soft_alarm_o`, `hard_alarm_o` and `revert_o`.
- R8: While disabled, ticks never raise an alarm.
- R9: A `pd_exit_i` pulse with `rearm_o`=1 sets `arm_o`, restarts the count and clears the alarms. With `rearm_o`=0 it changes nothing.
- R10: In dual mode, a kick after the soft alarm leaves `soft_alarm_o` set. The kick also postpones the hard alarm, which then needs two further unserviced expiries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_arm_i | input | 1 | Write data: enable |
| ctl_dual_i | input | 1 | Write data: 1 = soft and hard alarm, 0 = hard only |
| ctl_long_i | input | 1 | Write data: 1 = long time base, 0 = short |
| ctl_units_i | input | 3 | Write data: timeout in time-base units |
| ctl_rearm_i | input | 1 | Write data: auto re-arm after power-down exit |
| kick_i | input | 1 | Service pulse |
| tick_i | input | 1 | Prescaler pulse, one per short unit |
| pd_exit_i | input | 1 | Power-down exit pulse |
| arm_o | output | 1 | Enable field |
| dual_o | output | 1 | Alarm-mode field |
| long_o | output | 1 | Time-base field |
| units_o | output | 3 | Unit-count field |
| rearm_o | output | 1 | Auto re-arm field |
| soft_alarm_o | output | 1 | Soft alarm status |
| hard_alarm_o | output | 1 | Hard alarm status |
| revert_o | output | 1 | Request to return to the strapped frequency |
| sw_mode_clr_o | output | 1 | One-cycle pulse that clears the software clock-mode bit |

## Verification
The bench counts ticks up to the exact expiry edge for short and long bases and for a zero unit count. An off-by-one counter would alarm one tick early or late, and an unscaled long base would expire four times too soon. In dual mode it checks that the first expiry does not also raise the hard alarm, and that a kick after the soft alarm resets the two-stage sequence without dropping the soft flag. It checks that a mid-count rewrite reloads the count, that power-down exit only re-arms when allowed, and that the mode-clear pulse lasts one cycle rather than staying high.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned UNIT_W    = 3;
  localparam int unsigned LONG_MULT = 4;
  localparam int unsigned MAX_TICKS = ((1 << UNIT_W) - 1) * LONG_MULT;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  typedef struct packed {
    logic              arm;
    logic              dual;
    logic              long_base;
    logic [UNIT_W-1:0] units;
    logic              rearm;
  } wd_ctl_t;

  // Ticks in one timeout; a zero unit count is taken as one unit.
  function automatic logic [CNT_W-1:0] timeout_ticks(input logic [UNIT_W-1:0] units,
                                                     input logic long_base);
    int unsigned u;
    u = int'(units);
    if (u == 0) u = 1;
    if (long_base) u = u * LONG_MULT;
    return CNT_W'(u);
  endfunction
endpackage

// File: rtl/fwd_ctl.sv
module fwd_ctl
  import fwd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_i,
  input  wd_ctl_t wdata_i,
  input  logic    pd_exit_i,
  output wd_ctl_t ctl_o,
  output logic    restart_o
);
  wd_ctl_t ctl_q;
  logic    pd_rearm;

  assign pd_rearm  = pd_exit_i & ctl_q.rearm & ~wr_i;
  assign restart_o = wr_i | pd_rearm;
  assign ctl_o     = ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.arm       <= 1'b0;
      ctl_q.dual      <= 1'b0;
      ctl_q.long_base <= 1'b0;
      ctl_q.units     <= '1;
      ctl_q.rearm     <= 1'b0;
    end else if (wr_i) begin
      ctl_q <= wdata_i;
    end else if (pd_rearm) begin
      ctl_q.arm <= 1'b1;
    end
  end

  assert_pd_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_rearm |=> ctl_q.arm);
  assert_pd_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_exit_i && !ctl_q.rearm && !wr_i) |=> $stable(ctl_q));
endmodule

// File: rtl/fwd_timer.sv
module fwd_timer
  import fwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] elapsed_o
);
  logic [CNT_W-1:0] elapsed_q;
  logic             at_end;

  assign at_end    = (elapsed_q == limit_i - CNT_W'(1));
  assign expire_o  = run_i & tick_i & ~reload_i & at_end;
  assign elapsed_o = elapsed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 elapsed_q <= '0;
    else if (reload_i || !run_i) elapsed_q <= '0;
    else if (tick_i)            elapsed_q <= at_end ? '0 : elapsed_q + CNT_W'(1);
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (elapsed_q < limit_i));
  assert_expire_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (elapsed_q == '0));
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (elapsed_q == '0));
endmodule

// File: rtl/fwd_alarm.sv
module fwd_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic kick_i,
  input  logic expire_i,
  input  logic dual_i,
  output logic soft_o,
  output logic hard_o,
  output logic swclr_o
);
  logic soft_q, hard_q, phase_q, swclr_q;
  logic soft_fire, hard_fire;

  assign soft_fire = expire_i & dual_i & ~phase_q;
  assign hard_fire = expire_i & ~soft_fire;
  assign soft_o    = soft_q;
  assign hard_o    = hard_q;
  assign swclr_o   = swclr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q <= 1'b0; hard_q <= 1'b0; phase_q <= 1'b0; swclr_q <= 1'b0;
    end else if (clr_i) begin
      soft_q <= 1'b0; hard_q <= 1'b0; phase_q <= 1'b0; swclr_q <= 1'b0;
    end else begin
      swclr_q <= hard_fire;
      if (hard_fire) hard_q <= 1'b1;
      if (soft_fire) begin
        soft_q  <= 1'b1;
        phase_q <= 1'b1;
      end else if (kick_i) begin
        phase_q <= 1'b0;
      end
    end
  end

  assert_hard_after_soft_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_fire && dual_i) |-> soft_q);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!soft_q && !hard_q));
  assert_swclr_with_hard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    swclr_q |-> hard_q);
  assert_hard_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_q && !clr_i) |=> hard_q);
  assert_swclr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    swclr_q |=> !swclr_q);
endmodule

// File: rtl/fwd_top.sv
module fwd_top
  import fwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_i,
  input  logic              ctl_arm_i,
  input  logic              ctl_dual_i,
  input  logic              ctl_long_i,
  input  logic [UNIT_W-1:0] ctl_units_i,
  input  logic              ctl_rearm_i,
  input  logic              kick_i,
  input  logic              tick_i,
  input  logic              pd_exit_i,
  output logic              arm_o,
  output logic              dual_o,
  output logic              long_o,
  output logic [UNIT_W-1:0] units_o,
  output logic              rearm_o,
  output logic              soft_alarm_o,
  output logic              hard_alarm_o,
  output logic              revert_o,
  output logic              sw_mode_clr_o
);
  wd_ctl_t          wdata, ctl;
  logic             restart, run, kick_ok, reload, expire, hard;
  logic [CNT_W-1:0] limit, elapsed;

  assign wdata = '{arm: ctl_arm_i, dual: ctl_dual_i, long_base: ctl_long_i,
                   units: ctl_units_i, rearm: ctl_rearm_i};

  fwd_ctl u_ctl (.clk(clk), .rst_n(rst_n), .wr_i(ctl_wr_i), .wdata_i(wdata),
                 .pd_exit_i(pd_exit_i), .ctl_o(ctl), .restart_o(restart));

  assign limit   = timeout_ticks(ctl.units, ctl.long_base);
  assign run     = ctl.arm & ~hard;
  assign kick_ok = kick_i & run;
  assign reload  = restart | kick_ok;

  fwd_timer u_tmr (.clk(clk), .rst_n(rst_n), .run_i(run), .reload_i(reload),
                   .tick_i(tick_i), .limit_i(limit), .expire_o(expire),
                   .elapsed_o(elapsed));

  fwd_alarm u_alm (.clk(clk), .rst_n(rst_n), .clr_i(restart), .kick_i(kick_ok),
                   .expire_i(expire), .dual_i(ctl.dual), .soft_o(soft_alarm_o),
                   .hard_o(hard), .swclr_o(sw_mode_clr_o));

  assign hard_alarm_o = hard;
  assign revert_o     = hard;
  assign arm_o        = ctl.arm;
  assign dual_o       = ctl.dual;
  assign long_o       = ctl.long_base;
  assign units_o      = ctl.units;
  assign rearm_o      = ctl.rearm;

  assert_no_alarm_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.arm && !restart) |-> !expire);
  assert_kick_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> (elapsed == '0));
endmodule

// File: tb/sim_fwd_top.sv
module sim_fwd_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, c_arm = 0, c_dual = 0, c_long = 0, c_rearm = 0;
  logic [2:0] c_units = 0;
  logic kick = 0, tick = 0, pd_exit = 0;
  logic arm_o, dual_o, long_o, rearm_o, soft_o, hard_o, revert_o, swclr_o;
  logic [2:0] units_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  fwd_top u0 (.clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .ctl_arm_i(c_arm),
    .ctl_dual_i(c_dual), .ctl_long_i(c_long), .ctl_units_i(c_units),
    .ctl_rearm_i(c_rearm), .kick_i(kick), .tick_i(tick), .pd_exit_i(pd_exit),
    .arm_o(arm_o), .dual_o(dual_o), .long_o(long_o), .units_o(units_o),
    .rearm_o(rearm_o), .soft_alarm_o(soft_o), .hard_alarm_o(hard_o),
    .revert_o(revert_o), .sw_mode_clr_o(swclr_o));

  function automatic int want_ticks(int units, bit lng);
    int base = lng ? 4 : 1;
    return (units > 0 ? units : 1) * base;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(bit a, bit d, bit l, int u, bit r);
    c_arm = a; c_dual = d; c_long = l; c_units = 3'(u); c_rearm = r; ctl_wr = 1;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0; @(negedge clk);
    end
  endtask

  task automatic do_kick();
    kick = 1; @(negedge clk); kick = 0;
  endtask

  task automatic t_reset();
    chk("R1 arm", arm_o, 0); chk("R1 dual", dual_o, 0); chk("R1 long", long_o, 0);
    chk("R1 units", units_o, 7); chk("R1 rearm", rearm_o, 0);
    chk("R1 alarms", {soft_o, hard_o, revert_o, swclr_o}, 0);
  endtask

  task automatic t_hard_only();
    int n = want_ticks(3, 0);
    wr(1, 0, 0, 3, 0);
    ticks(n - 1);
    chk("R2 before expiry", hard_o, 0);
    tick = 1; @(negedge clk); tick = 0;
    chk("R2 hard at expiry", hard_o, 1);
    chk("R5 revert", revert_o, 1);
    chk("R5 mode clear pulse", swclr_o, 1);
    chk("R2 no soft in hard-only", soft_o, 0);
    @(negedge clk);
    chk("R5 pulse one cycle", swclr_o, 0);
    ticks(10);
    chk("R5 hard holds", hard_o, 1);
    do_kick();
    chk("R6 kick after hard ignored", {hard_o, revert_o}, 3);
    wr(1, 0, 0, 3, 0);
    chk("R7 write clears", {soft_o, hard_o, revert_o}, 0);
  endtask

  task automatic t_long_base();
    int n = want_ticks(2, 1);
    wr(1, 0, 1, 2, 0);
    ticks(n - 1);
    chk("R3 long base not early", hard_o, 0);
    ticks(1);
    chk("R3 long base expiry", hard_o, 1);
  endtask

  task automatic t_zero_units();
    wr(1, 0, 0, 0, 0);
    chk("R7 cleared", hard_o, 0);
    @(negedge clk); @(negedge clk);
    chk("R2 no tick no count", hard_o, 0);
    ticks(want_ticks(0, 0));
    chk("R2 zero units one tick", hard_o, 1);
  endtask

  task automatic t_dual();
    wr(1, 1, 0, 2, 0);
    ticks(2);
    chk("R4 soft first", soft_o, 1);
    chk("R4 no hard yet", hard_o, 0);
    ticks(1);
    chk("R4 hard waits", hard_o, 0);
    ticks(1);
    chk("R4 hard after second", hard_o, 1);
  endtask

  task automatic t_kick();
    wr(1, 0, 0, 3, 0);
    ticks(2); do_kick(); ticks(2);
    chk("R6 kick restarts", hard_o, 0);
    ticks(1);
    chk("R6 expiry after kick", hard_o, 1);
    wr(1, 0, 0, 3, 0);
    ticks(2); wr(1, 0, 0, 3, 0); ticks(2);
    chk("R7 rewrite reloads", hard_o, 0);
    ticks(1);
    chk("R7 expiry after rewrite", hard_o, 1);
  endtask

  task automatic t_disabled();
    wr(0, 1, 0, 1, 0);
    ticks(40);
    chk("R8 disabled no alarm", {soft_o, hard_o}, 0);
  endtask

  task automatic t_soft_persist();
    wr(1, 1, 0, 2, 0);
    ticks(2);
    chk("R10 soft set", soft_o, 1);
    do_kick();
    ticks(2);
    chk("R10 soft kept", soft_o, 1);
    chk("R10 hard postponed", hard_o, 0);
    ticks(2);
    chk("R10 hard after unserviced", hard_o, 1);
  endtask

  task automatic t_pd();
    wr(0, 0, 0, 2, 0);
    pd_exit = 1; @(negedge clk); pd_exit = 0;
    chk("R9 no rearm stays off", arm_o, 0);
    wr(1, 0, 0, 1, 1);
    ticks(1);
    chk("R9 prep alarm", hard_o, 1);
    wr(0, 0, 0, 1, 1);
    pd_exit = 1; @(negedge clk); pd_exit = 0;
    chk("R9 rearm sets arm", arm_o, 1);
    chk("R9 alarms clear", hard_o, 0);
    ticks(1);
    chk("R9 armed counts", hard_o, 1);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hard_only();
    t_long_base();
    t_zero_units();
    t_dual();
    t_kick();
    t_disabled();
    t_soft_persist();
    t_pd();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule